// File: doc/BRIEF.md
# Counter-mode line encryption sequencer

This block sits between a cache and external memory and protects 256-bit cache lines with counter-mode keystreams. Each keystream is built from three values: a per-line time stamp, the line address and a segment identifier. On a protected write, the line's stored time stamp is read and incremented, and keystream is requested. The plaintext is XORed with the keystream, the ciphertext goes to memory, and the new time stamp is written back. On a protected read, the stored time stamp is fetched and keystream requests are launched together with the memory fetch. The plaintext then appears one XOR after the ciphertext arrives.

Each request carries a protection level. Full protection uses and advances a stored time stamp. Confidentiality-only protection presents a zero time stamp and never touches the time-stamp store. No protection passes data straight through without asking for keystream. The keystream generator is an external unit behind a request/acknowledge port and returns 128 bits per acknowledge, so a line needs two requests. The block handles one access at a time and holds the cache side busy until it answers.

Top module: `line_crypt_seq`

## Requirements
- R1: After reset, `busy`, `rsp_valid`, `mem_req`, `ks_req`, `ts_rd_en`, `ts_wr_en` and `rollover` are all low.
- R2: The keystream request word `ks_in` is {time stamp (32), line address (16), part bit (1), segment (8)}, from most to least significant. A protected line takes exactly two acknowledged requests: part 0 first, supplying line bits [127:0], then part 1, supplying bits [255:128].
- R3: A full-protection write (level code 2'b10 or 2'b11) reads the line's time stamp and adds one. It writes plaintext XOR the keystream built from the new stamp to memory, and stores the new stamp only after the memory write is acknowledged.
- R4: On a protected read, the keystream requests are outstanding while the memory read is still pending, so keystream generation overlaps the fetch.
- R5: On a protected read, the returned data equals the fetched ciphertext XOR the keystream built from the stored time stamp. A stale stored stamp therefore yields different data.
- R6: A confidentiality-only access (level code 2'b01) presents a zero time-stamp field and performs no time-stamp read or write.
- R7: When a full-protection write finds the stored stamp at all ones, `rollover` pulses for one cycle with the request's segment on `rollover_seg`, and the stored stamp becomes zero.
- R8: A no-protection access (level code 2'b00) passes data unchanged in both directions. It makes no keystream request and no time-stamp access.
- R9: A request is accepted only while `busy` is low. `busy` then stays high until a one-cycle `rsp_valid`, after which it drops. Writes answer with zero data, and `req_valid` seen while busy is ignored.
- R10: `mem_req` and `ks_req` stay high with stable payloads until their acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Cache request strobe, sampled while idle |
| req_write | input | 1 | 1 = line write, 0 = line read |
| req_addr | input | 16 | Line address |
| req_seg | input | 8 | Segment identifier |
| req_level | input | 2 | Protection level code |
| req_wdata | input | 256 | Plaintext line for writes |
| busy | output | 1 | Access in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 256 | Read plaintext (zero for writes) |
| rollover | output | 1 | Time-stamp wrap pulse |
| rollover_seg | output | 8 | Segment whose stamp wrapped |
| mem_req | output | 1 | External memory request |
| mem_write | output | 1 | Memory write when high |
| mem_addr | output | 16 | Memory line address |
| mem_wdata | output | 256 | Line sent to memory |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 256 | Line from memory, valid with ack |
| ts_rd_en | output | 1 | Time-stamp read strobe (data next cycle) |
| ts_wr_en | output | 1 | Time-stamp write strobe |
| ts_addr | output | 16 | Time-stamp entry address |
| ts_wdata | output | 32 | Time stamp to store |
| ts_rdata | input | 32 | Stored time stamp |
| ks_req | output | 1 | Keystream request |
| ks_in | output | 57 | Keystream input word |
| ks_ack | input | 1 | Keystream acknowledge |
| ks_data | input | 128 | Keystream part, valid with ack |

## Verification
A wrong stored or incremented time stamp does not show at once. It shows on the ciphertext of the write that uses it, on the time-stamp store one access later, and as corrupted plaintext on the next protected read of that line. A mix-up of keystream part order or address bits shows on the first protected write, as a memory word that differs from the expected XOR. A sequencing fault, such as a read that waits for keystream before fetching or a request accepted while busy, shows within the same access. It appears as missing overlap, a stray memory write or an unexpected response.

// File: rtl/lcs_pkg.sv
// Shared types for the line encryption sequencer.
package lcs_pkg;

    // Protection applied to one access.
    typedef enum logic [1:0] {
        LVL_NONE = 2'b00,
        LVL_CONF = 2'b01,
        LVL_FULL = 2'b10
    } level_t;

    // Sequencer control states.
    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_TS_RD   = 3'd1,
        S_TS_WAIT = 3'd2,
        S_LAUNCH  = 3'd3,
        S_RUN     = 3'd4,
        S_WMEM    = 3'd5,
        S_TS_WR   = 3'd6,
        S_FIN     = 3'd7
    } state_t;

    // Map a raw level code; bit 1 set means full protection.
    function automatic level_t decode_level(input logic [1:0] raw);
        if (raw[1])      return LVL_FULL;
        else if (raw[0]) return LVL_CONF;
        else             return LVL_NONE;
    endfunction

endpackage

// File: rtl/lcs_ks_fetch.sv
// Keystream collector: issues one request per keystream part, in ascending
// part order, and assembles the full line keystream.
// Assumes: time stamp, address and segment inputs are held stable by the
// caller from start until done; start is a one-cycle pulse while idle.
module lcs_ks_fetch #(
    parameter int LINE_W = 256,
    parameter int KS_W   = 128,
    parameter int TS_W   = 32,
    parameter int ADDR_W = 16,
    parameter int SEG_W  = 8,
    localparam int PARTS  = LINE_W / KS_W,
    localparam int PART_W = (PARTS > 1) ? $clog2(PARTS) : 1,
    localparam int KIN_W  = TS_W + ADDR_W + PART_W + SEG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TS_W-1:0]   ts,
    input  logic [ADDR_W-1:0] line_addr,
    input  logic [SEG_W-1:0]  seg,
    output logic              ks_req,
    output logic [KIN_W-1:0]  ks_in,
    input  logic              ks_ack,
    input  logic [KS_W-1:0]   ks_data,
    output logic [LINE_W-1:0] ks_line,
    output logic              done
);

    logic              req_q;
    logic [PART_W-1:0] part_q;
    logic [LINE_W-1:0] line_q;
    logic              done_q;

    // Request sequencing and keystream assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            part_q <= '0;
            line_q <= '0;
            done_q <= 1'b0;
        end else if (start) begin
            req_q  <= 1'b1;
            part_q <= '0;
            done_q <= 1'b0;
        end else if (req_q && ks_ack) begin
            for (int p = 0; p < PARTS; p++) begin
                if (part_q == PART_W'(p)) line_q[p*KS_W +: KS_W] <= ks_data;
            end
            if (part_q == PART_W'(PARTS - 1)) begin
                req_q  <= 1'b0;
                done_q <= 1'b1;
            end else begin
                part_q <= part_q + 1'b1;
            end
        end
    end

    // Request word: stamp, address, part, segment.
    always_comb begin
        ks_in = {ts, line_addr, part_q, seg};
    end

    assign ks_req  = req_q;
    assign ks_line = line_q;
    assign done    = done_q;

endmodule

// File: rtl/lcs_mem_port.sv
// External memory requester: registers one read or write, holds the request
// until acknowledged and captures read data.
// Assumes: start only arrives while no request is pending.
module lcs_mem_port #(
    parameter int ADDR_W = 16,
    parameter int LINE_W = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LINE_W-1:0] wdata,
    output logic              mem_req,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [LINE_W-1:0] mem_rdata,
    output logic [LINE_W-1:0] rdata,
    output logic              done
);

    logic              req_q;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LINE_W-1:0] wdata_q;
    logic [LINE_W-1:0] rdata_q;
    logic              done_q;

    // Request hold, completion flag and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else if (start) begin
            req_q   <= 1'b1;
            wr_q    <= wr;
            addr_q  <= addr;
            wdata_q <= wdata;
            done_q  <= 1'b0;
        end else if (req_q && mem_ack) begin
            req_q  <= 1'b0;
            done_q <= 1'b1;
            if (!wr_q) rdata_q <= mem_rdata;
        end
    end

    assign mem_req   = req_q;
    assign mem_write = wr_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
    assign rdata     = rdata_q;
    assign done      = done_q;

endmodule

// File: rtl/line_crypt_seq.sv
// Counter-mode line encryption sequencer. Accepts one cache access at a
// time, fetches and advances per-line time stamps for fully protected
// lines, gathers keystream, and XORs it onto write or read data.
// Assumes: the time-stamp store answers a read one cycle after ts_rd_en;
// memory and keystream units acknowledge each request exactly once.
module line_crypt_seq
    import lcs_pkg::*;
#(
    parameter int LINE_W = 256,
    parameter int KS_W   = 128,
    parameter int TS_W   = 32,
    parameter int ADDR_W = 16,
    parameter int SEG_W  = 8,
    localparam int PARTS  = LINE_W / KS_W,
    localparam int PART_W = (PARTS > 1) ? $clog2(PARTS) : 1,
    localparam int KIN_W  = TS_W + ADDR_W + PART_W + SEG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [1:0]        req_level,
    input  logic [LINE_W-1:0] req_wdata,
    output logic              busy,
    output logic              rsp_valid,
    output logic [LINE_W-1:0] rsp_rdata,
    output logic              rollover,
    output logic [SEG_W-1:0]  rollover_seg,
    output logic              mem_req,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [LINE_W-1:0] mem_rdata,
    output logic              ts_rd_en,
    output logic              ts_wr_en,
    output logic [ADDR_W-1:0] ts_addr,
    output logic [TS_W-1:0]   ts_wdata,
    input  logic [TS_W-1:0]   ts_rdata,
    output logic              ks_req,
    output logic [KIN_W-1:0]  ks_in,
    input  logic              ks_ack,
    input  logic [KS_W-1:0]   ks_data
);

    state_t            state_q;
    level_t            lvl_q;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [SEG_W-1:0]  seg_q;
    logic [LINE_W-1:0] wdata_q;
    logic [TS_W-1:0]   cur_ts_q;
    logic [LINE_W-1:0] rsp_q;
    logic              roll_q;
    logic [SEG_W-1:0]  roll_seg_q;

    logic              prot;
    logic              ks_start;
    logic              mem_start;
    logic [LINE_W-1:0] mem_wd_sel;
    logic [LINE_W-1:0] ks_line;
    logic              ks_done;
    logic [LINE_W-1:0] mem_rd_q;
    logic              mem_done;
    logic [TS_W-1:0]   ks_ts;

    assign prot  = (lvl_q != LVL_NONE);
    // Confidentiality-only lines present a zero stamp field.
    assign ks_ts = (lvl_q == LVL_FULL) ? cur_ts_q : '0;

    // Launch decisions for the keystream and memory units.
    always_comb begin
        ks_start   = 1'b0;
        mem_start  = 1'b0;
        mem_wd_sel = wdata_q;
        case (state_q)
            S_LAUNCH: begin
                ks_start  = prot;
                mem_start = !wr_q || !prot;
            end
            S_RUN: begin
                if (prot && wr_q && ks_done) begin
                    mem_start  = 1'b1;
                    mem_wd_sel = wdata_q ^ ks_line;
                end
            end
            default: ;
        endcase
    end

    // Main access sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            lvl_q      <= LVL_NONE;
            wr_q       <= 1'b0;
            addr_q     <= '0;
            seg_q      <= '0;
            wdata_q    <= '0;
            cur_ts_q   <= '0;
            rsp_q      <= '0;
            roll_q     <= 1'b0;
            roll_seg_q <= '0;
        end else begin
            roll_q <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        lvl_q    <= decode_level(req_level);
                        wr_q     <= req_write;
                        addr_q   <= req_addr;
                        seg_q    <= req_seg;
                        wdata_q  <= req_wdata;
                        cur_ts_q <= '0;
                        state_q  <= (decode_level(req_level) == LVL_FULL) ? S_TS_RD : S_LAUNCH;
                    end
                end
                S_TS_RD: state_q <= S_TS_WAIT;
                S_TS_WAIT: begin
                    if (wr_q) begin
                        cur_ts_q <= ts_rdata + 1'b1;
                        if (&ts_rdata) begin
                            roll_q     <= 1'b1;
                            roll_seg_q <= seg_q;
                        end
                    end else begin
                        cur_ts_q <= ts_rdata;
                    end
                    state_q <= S_LAUNCH;
                end
                S_LAUNCH: state_q <= S_RUN;
                S_RUN: begin
                    if (prot && wr_q) begin
                        if (ks_done) state_q <= S_WMEM;
                    end else if (mem_done && (ks_done || !prot)) begin
                        if (wr_q)      rsp_q <= '0;
                        else if (prot) rsp_q <= mem_rd_q ^ ks_line;
                        else           rsp_q <= mem_rd_q;
                        state_q <= S_FIN;
                    end
                end
                S_WMEM: begin
                    if (mem_done) begin
                        rsp_q   <= '0;
                        state_q <= (lvl_q == LVL_FULL) ? S_TS_WR : S_FIN;
                    end
                end
                S_TS_WR: state_q <= S_FIN;
                S_FIN:   state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    lcs_ks_fetch #(
        .LINE_W(LINE_W), .KS_W(KS_W), .TS_W(TS_W), .ADDR_W(ADDR_W), .SEG_W(SEG_W)
    ) u_ks (
        .clk(clk), .rst_n(rst_n), .start(ks_start),
        .ts(ks_ts), .line_addr(addr_q), .seg(seg_q),
        .ks_req(ks_req), .ks_in(ks_in), .ks_ack(ks_ack), .ks_data(ks_data),
        .ks_line(ks_line), .done(ks_done)
    );

    lcs_mem_port #(
        .ADDR_W(ADDR_W), .LINE_W(LINE_W)
    ) u_mem (
        .clk(clk), .rst_n(rst_n), .start(mem_start), .wr(wr_q),
        .addr(addr_q), .wdata(mem_wd_sel),
        .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rdata(mem_rd_q), .done(mem_done)
    );

    assign busy         = (state_q != S_IDLE);
    assign rsp_valid    = (state_q == S_FIN);
    assign rsp_rdata    = rsp_q;
    assign rollover     = roll_q;
    assign rollover_seg = roll_seg_q;
    assign ts_rd_en     = (state_q == S_TS_RD);
    assign ts_wr_en     = (state_q == S_TS_WR);
    assign ts_addr      = addr_q;
    assign ts_wdata     = cur_ts_q;

endmodule

// Property checker for the sequencer, attached by bind below.
// Assumes: lvl carries the latched protection level of the current access.
module lcs_checker #(
    parameter int TS_W  = 32,
    parameter int KIN_W = 57
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             rsp_valid,
    input logic             rollover,
    input logic             mem_req,
    input logic             mem_write,
    input logic [15:0]      mem_addr,
    input logic             mem_ack,
    input logic             ts_rd_en,
    input logic             ts_wr_en,
    input logic             ks_req,
    input logic [KIN_W-1:0] ks_in,
    input logic             ks_ack,
    input logic [1:0]       lvl
);

    // R10: keystream request and payload hold until acknowledged.
    assert_ks_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ks_req && !ks_ack) |=> (ks_req && $stable(ks_in)));

    // R10: memory request and payload hold until acknowledged.
    assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_write)));

    // R9: completion is a single pulse and releases busy.
    assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && !busy));

    // R9: no external activity while idle.
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !ks_req && !ts_wr_en && !ts_rd_en));

    // R6: confidentiality-only requests carry a zero stamp field.
    assert_conf_ts_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && lvl == 2'b01 && ks_req) |-> (ks_in[KIN_W-1 -: TS_W] == '0));

    // R6: stamp store touched only for full protection.
    assert_conf_no_ts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && lvl != 2'b10) |-> (!ts_wr_en && !ts_rd_en));

    // R8: no keystream traffic for unprotected accesses.
    assert_none_noks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && lvl == 2'b00) |-> !ks_req);

    // R7: rollover is a one-cycle pulse.
    assert_roll_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rollover |=> !rollover);

    // R3: the stamp is stored only after the memory write has finished.
    assert_ts_after_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ts_wr_en |-> !mem_req);

endmodule

bind line_crypt_seq lcs_checker #(.TS_W(TS_W), .KIN_W(KIN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .rsp_valid(rsp_valid),
    .rollover(rollover), .mem_req(mem_req), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .ts_rd_en(ts_rd_en),
    .ts_wr_en(ts_wr_en), .ks_req(ks_req), .ks_in(ks_in), .ks_ack(ks_ack),
    .lvl(lvl_q)
);

// File: tb/sim_line_crypt_seq.sv
`timescale 1ns/1ps
// Scoreboard bench for the line encryption sequencer.
module sim_line_crypt_seq;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [15:0]  req_addr = '0;
    logic [7:0]   req_seg = '0;
    logic [1:0]   req_level = '0;
    logic [255:0] req_wdata = '0;
    logic         busy, rsp_valid, rollover;
    logic [255:0] rsp_rdata;
    logic [7:0]   rollover_seg;
    logic         mem_req, mem_write;
    logic [15:0]  mem_addr;
    logic [255:0] mem_wdata;
    logic         mem_ack = 1'b0;
    logic [255:0] mem_rdata = '0;
    logic         ts_rd_en, ts_wr_en;
    logic [15:0]  ts_addr;
    logic [31:0]  ts_wdata;
    logic [31:0]  ts_rdata = '0;
    logic         ks_req;
    logic [56:0]  ks_in;
    logic         ks_ack = 1'b0;
    logic [127:0] ks_data = '0;

    int tests = 0;
    int failed = 0;

    always #2.5 clk = ~clk;

    line_crypt_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_seg(req_seg), .req_level(req_level),
        .req_wdata(req_wdata), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rollover(rollover), .rollover_seg(rollover_seg),
        .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .ts_rd_en(ts_rd_en), .ts_wr_en(ts_wr_en), .ts_addr(ts_addr),
        .ts_wdata(ts_wdata), .ts_rdata(ts_rdata), .ks_req(ks_req),
        .ks_in(ks_in), .ks_ack(ks_ack), .ks_data(ks_data)
    );

    // Deterministic keystream stand-in.
    function automatic logic [127:0] ksf(input logic [56:0] x);
        return {x[56:25] ^ 32'hA5A5A5A5, x[31:0] * 32'h9E3779B1,
                ~x[56:25], x[31:0] + 32'h01234567};
    endfunction

    function automatic logic [255:0] line_ks(input logic [31:0] ts, input logic [15:0] a,
                                             input logic [7:0] s);
        return {ksf({ts, a, 1'b1, s}), ksf({ts, a, 1'b0, s})};
    endfunction

    // Memory stand-in with a fixed latency.
    logic [255:0] mem_model [0:15];
    int mcnt;
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            mcnt <= 0;
            for (int i = 0; i < 16; i++) mem_model[i] <= '0;
        end else if (mem_req && !mem_ack) begin
            if (mcnt == 3) begin
                mem_ack <= 1'b1;
                mcnt <= 0;
                if (mem_write) mem_model[mem_addr[3:0]] <= mem_wdata;
                else mem_rdata <= mem_model[mem_addr[3:0]];
            end else begin
                mcnt <= mcnt + 1;
                mem_ack <= 1'b0;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // Keystream stand-in.
    int kcnt;
    always @(posedge clk) begin
        if (!rst_n) begin
            ks_ack <= 1'b0;
            kcnt <= 0;
        end else if (ks_req && !ks_ack) begin
            if (kcnt == 1) begin
                ks_ack <= 1'b1;
                kcnt <= 0;
                ks_data <= ksf(ks_in);
            end else begin
                kcnt <= kcnt + 1;
                ks_ack <= 1'b0;
            end
        end else begin
            ks_ack <= 1'b0;
        end
    end

    // Time-stamp store stand-in with a preload port for the bench.
    logic [31:0] ts_ram [0:15];
    logic        poke_en = 1'b0;
    logic [3:0]  poke_addr = '0;
    logic [31:0] poke_val = '0;
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) ts_ram[i] <= '0;
        end else begin
            if (ts_rd_en) ts_rdata <= ts_ram[ts_addr[3:0]];
            if (ts_wr_en) ts_ram[ts_addr[3:0]] <= ts_wdata;
            if (poke_en) ts_ram[poke_addr] <= poke_val;
        end
    end

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report;
        $display("[TB] %0d tests run, %0d failed", tests, failed);
    endtask

    // Scoreboard queues.
    logic [255:0] exp_rsp [$];
    string        rsp_tag [$];
    logic [255:0] exp_wr [$];
    string        wr_tag [$];

    int n_ks = 0, n_tsw = 0, n_tsr = 0, n_ovl = 0, n_roll = 0;
    logic [7:0] last_roll_seg = '0;

    // Monitor: compares responses and memory writes against the queues.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid) begin
                if (exp_rsp.size() == 0) chk("R9 unexpected response", rsp_rdata, '0 - 256'd1);
                else chk(rsp_tag.pop_front(), rsp_rdata, exp_rsp.pop_front());
            end
            if (mem_req && mem_ack && mem_write) begin
                if (exp_wr.size() == 0) chk("R9 unexpected memory write", mem_wdata, '0 - 256'd1);
                else chk(wr_tag.pop_front(), mem_wdata, exp_wr.pop_front());
            end
            if (ks_req && ks_ack) n_ks++;
            if (ts_wr_en) n_tsw++;
            if (ts_rd_en) n_tsr++;
            if (ks_req && mem_req && !mem_write) n_ovl++;
            if (rollover) begin
                n_roll++;
                last_roll_seg = rollover_seg;
            end
        end
    end

    // Watchdog.
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 50000) begin
            tests++;
            failed++;
            $display("FAIL watchdog expired");
            report();
            $finish;
        end
    end

    task automatic wait_idle;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
        @(negedge clk);
    endtask

    // Driver: one access, then wait for completion.
    task automatic access(input logic w, input logic [1:0] lvl, input logic [15:0] a,
                          input logic [7:0] s, input logic [255:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = w;
        req_level = lvl;
        req_addr  = a;
        req_seg   = s;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
    endtask

    task automatic poke(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        poke_en = 1'b1;
        poke_addr = a;
        poke_val = v;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    initial begin : stim
        logic [255:0] d1, d2, d3, d4, d5, d6, d7;
        int k0, w0, r0, o0, g0;
        d1 = {8{32'h11223344}};
        d2 = {8{32'hCAFEF00D}} ^ 256'h5;
        d3 = {4{64'h0123456789ABCDEF}};
        d4 = {16{16'hBEEF}};
        d5 = {8{32'h0F0F1234}};
        d6 = {8{32'h600DD00D}};
        d7 = {8{32'hDEADBEEF}};

        repeat (4) @(negedge clk);
        chk("R1 busy after reset", 256'(busy), 256'(0));
        chk("R1 request lines after reset", 256'({mem_req, ks_req, ts_rd_en, ts_wr_en}), 256'(0));
        chk("R1 rsp/rollover after reset", 256'({rsp_valid, rollover}), 256'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R8: bypass write and read.
        k0 = n_ks; r0 = n_tsr;
        exp_wr.push_back(d1); wr_tag.push_back("R8 bypass write data");
        exp_rsp.push_back('0); rsp_tag.push_back("R9 write response zero");
        access(1'b1, 2'b00, 16'd1, 8'd2, d1);
        exp_rsp.push_back(d1); rsp_tag.push_back("R8 bypass read data");
        access(1'b0, 2'b00, 16'd1, 8'd2, '0);
        chk("R8 no keystream requests", 256'(n_ks - k0), 256'(0));
        chk("R8 no stamp reads", 256'(n_tsr - r0), 256'(0));

        // R6/R2: confidentiality-only write and read.
        k0 = n_ks; r0 = n_tsr; w0 = n_tsw; o0 = n_ovl;
        exp_wr.push_back(d2 ^ line_ks(32'd0, 16'd2, 8'd3)); wr_tag.push_back("R6 R2 conf ciphertext");
        exp_rsp.push_back('0); rsp_tag.push_back("R9 write response zero");
        access(1'b1, 2'b01, 16'd2, 8'd3, d2);
        chk("R2 two keystream parts per line", 256'(n_ks - k0), 256'(2));
        exp_rsp.push_back(d2); rsp_tag.push_back("R5 conf read plaintext");
        access(1'b0, 2'b01, 16'd2, 8'd3, '0);
        chk("R6 no stamp writes", 256'(n_tsw - w0), 256'(0));
        chk("R6 no stamp reads", 256'(n_tsr - r0), 256'(0));
        chk("R4 conf read overlap", 256'(n_ovl - o0 > 0), 256'(1));

        // R3: full-protection writes advance the stamp.
        g0 = n_roll;
        exp_wr.push_back(d3 ^ line_ks(32'd1, 16'd4, 8'd5)); wr_tag.push_back("R3 first full write ciphertext");
        exp_rsp.push_back('0); rsp_tag.push_back("R9 write response zero");
        access(1'b1, 2'b10, 16'd4, 8'd5, d3);
        chk("R3 stamp stored as 1", 256'(ts_ram[4]), 256'(1));
        exp_wr.push_back(d4 ^ line_ks(32'd2, 16'd4, 8'd5)); wr_tag.push_back("R3 second full write ciphertext");
        exp_rsp.push_back('0); rsp_tag.push_back("R9 write response zero");
        access(1'b1, 2'b10, 16'd4, 8'd5, d4);
        chk("R3 stamp stored as 2", 256'(ts_ram[4]), 256'(2));
        chk("R7 no rollover without wrap", 256'(n_roll - g0), 256'(0));

        // R4/R5: full-protection read.
        w0 = n_tsw; r0 = n_tsr; o0 = n_ovl;
        exp_rsp.push_back(d4); rsp_tag.push_back("R5 full read plaintext");
        access(1'b0, 2'b10, 16'd4, 8'd5, '0);
        chk("R4 keystream overlaps fetch", 256'(n_ovl - o0 > 0), 256'(1));
        chk("R5 one stamp read", 256'(n_tsr - r0), 256'(1));
        chk("R5 read stores no stamp", 256'(n_tsw - w0), 256'(0));

        // R8: bypass read shows the raw ciphertext.
        exp_rsp.push_back(d4 ^ line_ks(32'd2, 16'd4, 8'd5)); rsp_tag.push_back("R8 bypass read of ciphertext");
        access(1'b0, 2'b00, 16'd4, 8'd5, '0);

        // R7: stamp wrap.
        poke(4'd6, 32'hFFFFFFFF);
        g0 = n_roll;
        exp_wr.push_back(d5 ^ line_ks(32'd0, 16'd6, 8'd9)); wr_tag.push_back("R7 wrapped stamp ciphertext");
        exp_rsp.push_back('0); rsp_tag.push_back("R9 write response zero");
        access(1'b1, 2'b10, 16'd6, 8'd9, d5);
        chk("R7 one rollover pulse", 256'(n_roll - g0), 256'(1));
        chk("R7 rollover segment", 256'(last_roll_seg), 256'(9));
        chk("R7 stamp stored as 0", 256'(ts_ram[6]), 256'(0));

        // R5: stale stamp gives a different result.
        poke(4'd4, 32'd1);
        exp_rsp.push_back(d4 ^ line_ks(32'd2, 16'd4, 8'd5) ^ line_ks(32'd1, 16'd4, 8'd5));
        rsp_tag.push_back("R5 stale stamp read");
        access(1'b0, 2'b10, 16'd4, 8'd5, '0);

        // R9: request during busy is ignored.
        exp_wr.push_back(d6 ^ line_ks(32'd1, 16'd8, 8'd1)); wr_tag.push_back("R9 busy-time write ciphertext");
        exp_rsp.push_back('0); rsp_tag.push_back("R9 write response zero");
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_level = 2'b10;
        req_addr = 16'd8; req_seg = 8'd1; req_wdata = d6;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R9 busy during access", 256'(busy), 256'(1));
        req_valid = 1'b1; req_write = 1'b1; req_level = 2'b00;
        req_addr = 16'd9; req_seg = 8'd0; req_wdata = d7;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        exp_rsp.push_back('0); rsp_tag.push_back("R9 ignored request left line zero");
        access(1'b0, 2'b00, 16'd9, 8'd0, '0);

        // R3: level code 2'b11 behaves as full protection.
        exp_wr.push_back(d7 ^ line_ks(32'd1, 16'd10, 8'd4)); wr_tag.push_back("R3 code 2'b11 ciphertext");
        exp_rsp.push_back('0); rsp_tag.push_back("R9 write response zero");
        access(1'b1, 2'b11, 16'd10, 8'd4, d7);
        chk("R3 code 2'b11 stamp stored", 256'(ts_ram[10]), 256'(1));

        repeat (5) @(negedge clk);
        chk("R9 all responses seen", 256'(exp_rsp.size()), 256'(0));
        chk("R3 all memory writes seen", 256'(exp_wr.size()), 256'(0));
        report();
        $finish;
    end

endmodule